// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block lets synchronous logic read and write an external asynchronous static RAM of 128K words by 16 bits. A requester presents a request with a valid flag, a write flag, a word address, write data and a two-bit lane mask. The controller then sequences the memory's active-low chip enable, write strobe, output enable and two byte enables. Every phase lasts a whole number of system clocks. These counts come from nanosecond minima given as parameters, and each is rounded up against the configured clock period.

The controller is a state machine with six states. `ST_IDLE` holds every strobe high and waits for a request. `ST_TURN` inserts a bus-turnaround gap, with all strobes high, whenever the direction differs from the previous access. `ST_WSETUP` drives address, chip enable and byte enables for one clock before the write strobe falls. `ST_WSTROBE` holds the write strobe low and drives the data bus. `ST_RACCESS` holds chip enable and output enable low until the address-to-data time has elapsed. `ST_PAUSE` pads the access out to the full cycle time.

The transitions are as follows. IDLE goes to TURN on a direction change. Otherwise IDLE goes to WSETUP for a write or to RACCESS for a read. TURN goes to WSETUP or RACCESS. WSETUP goes to WSTROBE. WSTROBE and RACCESS go to PAUSE when cycle time remains, and to IDLE otherwise. PAUSE goes to IDLE. The requester holds valid and the request fields until a one-cycle ready pulse and drops valid afterwards. On a read, the captured data is presented with that pulse.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and after reset, with no request, chip enable, write strobe, output enable and both byte enables are high, the data bus driver is off and ready is low.
- R2: A write holds chip enable and the write strobe low. The data bus is driven with the write data exactly while the write strobe is low, for WP cycles: the largest of ceil(tWP/T), ceil(tAW/T)-1 and ceil(tDS/T), which is 4 at the default 10 ns clock.
- R3: Address, chip enable and byte enables are valid one clock before the write strobe falls. The address on the bus equals the requested address and stays stable until the strobe rises and through a read.
- R4: Mask bit 0 enables the lower byte lane (data bits 7:0, lower byte enable), and mask bit 1 enables the upper lane (bits 15:8, upper byte enable). A write with mask 00 leaves both byte enables high and changes no stored data.
- R5: A read holds chip enable and output enable low with the write strobe high for AA cycles: the larger of ceil(tAA/T) and ceil(tOE/T), which is 6 by default. Data is captured at the edge that ends that phase. Lanes not selected by the mask read as zero.
- R6: Ready is high for exactly one cycle per access, in the cycle after the write strobe rises or after read capture. Read data stays unchanged until the next read completes.
- R7: Chip enable does not fall again earlier than min(ceil(tWC/T), ceil(tRC/T)) cycles after its previous fall, which is 6 by default.
- R8: When the direction changes, output enable falls no sooner than ceil(tTA/T) cycles after the data driver is released, which is 3 by default.
- R9: A request is taken only in IDLE with ready low. Changes on the request inputs while an access is in flight do not affect that access.
- R10: Each phase counter counts down by one per clock from its loaded length, so every phase lasts exactly its derived cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 lower byte, bit 1 upper byte |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Captured read data, unselected lanes zero |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_addr | output | 17 | Memory address bus |
| mem_dq_o | output | 16 | Data bus outgoing value |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_i | input | 16 | Data bus incoming value |

## Verification
Writes are applied with all three non-empty masks and with the empty mask, then read back at full width, which separates a lane-steering fault from a missed commit. Reads with single-lane masks show whether unselected lanes are zeroed. The memory model returns valid data only after the full access time, so capturing one edge early produces a wrong word. Back-to-back pairs in both direction orders tell the turnaround gap apart from the ordinary cycle-time pad. A request whose fields change mid-flight shows whether the controller latched them at acceptance.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WSETUP,
        ST_WSTROBE,
        ST_RACCESS,
        ST_PAUSE
    } ctl_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cnt_width(input int v);
        return (v < 1) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    // R10: a running phase shortens by exactly one clock per edge
    p_step_by_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_lane_steer.sv
module sram_lane_steer #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    active,
    input  logic [LANES-1:0]        lane_sel,
    input  logic [LANES*LANE_W-1:0] rd_raw,
    output logic [LANES-1:0]        lane_en_n,
    output logic [LANES*LANE_W-1:0] rd_kept
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_en_n[g] = ~(active & lane_sel[g]);
        assign rd_kept[g*LANE_W +: LANE_W] =
            lane_sel[g] ? rd_raw[g*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 16,
    parameter int CLK_PS  = 10000,
    parameter int T_WP_PS = 40000,
    parameter int T_AW_PS = 45000,
    parameter int T_DS_PS = 25000,
    parameter int T_WC_PS = 55000,
    parameter int T_AA_PS = 55000,
    parameter int T_OE_PS = 25000,
    parameter int T_RC_PS = 55000,
    parameter int T_TA_PS = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_mask,
    output logic              req_ready,
    output logic [DATA_W-1:0] req_rdata,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);

    localparam int LANES   = 2;
    localparam int LANE_W  = DATA_W / LANES;
    localparam int WP_CYC  = max2(max2(ceil_div(T_WP_PS, CLK_PS), ceil_div(T_AW_PS, CLK_PS) - 1),
                                  max2(ceil_div(T_DS_PS, CLK_PS), 1));
    localparam int AA_CYC  = max2(max2(ceil_div(T_AA_PS, CLK_PS), ceil_div(T_OE_PS, CLK_PS)), 1);
    localparam int WC_CYC  = ceil_div(T_WC_PS, CLK_PS);
    localparam int RC_CYC  = ceil_div(T_RC_PS, CLK_PS);
    localparam int WR_REST = max2(WC_CYC - 1 - WP_CYC, 0);
    localparam int RD_REST = max2(RC_CYC - AA_CYC, 0);
    localparam int TA_CYC  = ceil_div(T_TA_PS, CLK_PS);
    localparam int LONGEST = max2(max2(max2(WP_CYC, AA_CYC), max2(WR_REST, RD_REST)),
                                  max2(TA_CYC, max2(WC_CYC, RC_CYC)));
    localparam int CW      = cnt_width(LONGEST);
    localparam int MIN_GAP = (WC_CYC < RC_CYC) ? WC_CYC : RC_CYC;

    ctl_state_e state_q, state_d;

    logic              accept, need_turn, phase_done, phase_load;
    logic [CW-1:0]     phase_val;
    logic              wr_q, have_dir_q, ready_q, strobe_on;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q, rd_kept;
    logic [1:0]        mask_q, lane_en_n;

    assign accept    = (state_q == ST_IDLE) && req_valid && !ready_q;
    assign need_turn = have_dir_q && (req_write != wr_q) && (TA_CYC > 0);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (need_turn)      state_d = ST_TURN;
                    else if (req_write) state_d = ST_WSETUP;
                    else                state_d = ST_RACCESS;
                end
            end
            ST_TURN:    if (phase_done) state_d = wr_q ? ST_WSETUP : ST_RACCESS;
            ST_WSETUP:  state_d = ST_WSTROBE;
            ST_WSTROBE: if (phase_done) state_d = (WR_REST > 0) ? ST_PAUSE : ST_IDLE;
            ST_RACCESS: if (phase_done) state_d = (RD_REST > 0) ? ST_PAUSE : ST_IDLE;
            ST_PAUSE:   if (phase_done) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // phase length loaded on every entry into a timed state
    always_comb begin
        phase_load = (state_d != state_q) && (state_d != ST_IDLE);
        unique case (state_d)
            ST_TURN:    phase_val = CW'(TA_CYC - 1);
            ST_WSTROBE: phase_val = CW'(WP_CYC - 1);
            ST_RACCESS: phase_val = CW'(AA_CYC - 1);
            ST_PAUSE:   phase_val = wr_q ? CW'(WR_REST - 1) : CW'(RD_REST - 1);
            default:    phase_val = '0;
        endcase
    end

    sram_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (phase_load),
        .load_val (phase_val),
        .done     (phase_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request latch, capture and ready
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            wdata_q    <= '0;
            mask_q     <= '0;
            wr_q       <= 1'b0;
            have_dir_q <= 1'b0;
            ready_q    <= 1'b0;
            rdata_q    <= '0;
        end else begin
            if (accept) begin
                addr_q     <= req_addr;
                wdata_q    <= req_wdata;
                mask_q     <= req_mask;
                wr_q       <= req_write;
                have_dir_q <= 1'b1;
            end
            ready_q <= phase_done &&
                       (state_q == ST_WSTROBE || state_q == ST_RACCESS);
            if (state_q == ST_RACCESS && phase_done) begin
                rdata_q <= rd_kept;
            end
        end
    end

    // strobe outputs
    always_comb begin
        mem_ce_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_dq_oe = 1'b0;
        strobe_on = 1'b0;
        unique case (state_q)
            ST_WSETUP: begin
                mem_ce_n  = 1'b0;
                strobe_on = 1'b1;
            end
            ST_WSTROBE: begin
                mem_ce_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
                strobe_on = 1'b1;
            end
            ST_RACCESS: begin
                mem_ce_n  = 1'b0;
                mem_oe_n  = 1'b0;
                strobe_on = 1'b1;
            end
            default: ;
        endcase
    end

    sram_lane_steer #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
        .active    (strobe_on),
        .lane_sel  (mask_q),
        .rd_raw    (mem_dq_i),
        .lane_en_n (lane_en_n),
        .rd_kept   (rd_kept)
    );

    assign mem_lb_n  = lane_en_n[0];
    assign mem_ub_n  = lane_en_n[1];
    assign mem_addr  = addr_q;
    assign mem_dq_o  = wdata_q;
    assign req_ready = ready_q;
    assign req_rdata = rdata_q;

    // ---------------- checks ----------------
    logic [CW-1:0] rel_cnt, ce_gap;
    logic          ce_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel_cnt <= CW'(TA_CYC);
            ce_gap  <= CW'(LONGEST);
            ce_n_q  <= 1'b1;
        end else begin
            if (mem_dq_oe)                 rel_cnt <= '0;
            else if (rel_cnt < CW'(TA_CYC)) rel_cnt <= rel_cnt + 1'b1;
            if (ce_n_q && !mem_ce_n)       ce_gap <= CW'(1);
            else if (ce_gap < CW'(LONGEST)) ce_gap <= ce_gap + 1'b1;
            ce_n_q <= mem_ce_n;
        end
    end

    // R3: strobe falls only after a clock of chip select with a settled address
    p_addr_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(!mem_ce_n) && $stable(mem_addr)));

    // R3: address held while the strobe is low
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> $stable(mem_addr));

    // R5: never output-enable and write strobe together
    p_oe_we_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // R6: ready is a single-cycle pulse
    p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    // R7: minimum spacing of chip-enable assertions
    p_cycle_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> (ce_gap >= CW'(MIN_GAP)));

    // R8: bus released long enough before output enable
    p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> (rel_cnt >= CW'(TA_CYC)));

    // R9: latched request frozen while busy
    p_busy_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(addr_q) && $stable(wdata_q) && $stable(mask_q)));

endmodule

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;

    localparam int WE_W  = 4;   // max(ceil 40/10, ceil 45/10 - 1, ceil 25/10)
    localparam int OE_W  = 6;   // max(ceil 55/10, ceil 25/10)
    localparam int TA_W  = 3;   // ceil 25/10
    localparam int CYC_W = 6;   // ceil 55/10
    localparam int NVEC  = 14;

    // {write, addr[16:0], wdata[15:0], mask[1:0], expected read[15:0]}
    localparam logic [51:0] VEC [0:NVEC-1] = '{
        {1'b1, 17'h00001, 16'h1234, 2'b11, 16'h0000},
        {1'b0, 17'h00001, 16'h0000, 2'b11, 16'h1234},
        {1'b1, 17'h00001, 16'hABCD, 2'b01, 16'h0000},
        {1'b0, 17'h00001, 16'h0000, 2'b11, 16'h12CD},
        {1'b1, 17'h00001, 16'h5566, 2'b10, 16'h0000},
        {1'b0, 17'h00001, 16'h0000, 2'b11, 16'h55CD},
        {1'b0, 17'h00001, 16'h0000, 2'b01, 16'h00CD},
        {1'b0, 17'h00001, 16'h0000, 2'b10, 16'h5500},
        {1'b1, 17'h1FFFF, 16'hFFFF, 2'b11, 16'h0000},
        {1'b1, 17'h00002, 16'h0F0F, 2'b11, 16'h0000},
        {1'b0, 17'h1FFFF, 16'h0000, 2'b11, 16'hFFFF},
        {1'b0, 17'h00002, 16'h0000, 2'b11, 16'h0F0F},
        {1'b1, 17'h00002, 16'h0000, 2'b00, 16'h0000},
        {1'b0, 17'h00002, 16'h0000, 2'b11, 16'h0F0F}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_ready;
    logic [16:0] req_addr, mem_addr;
    logic [15:0] req_wdata, req_rdata, mem_dq_o, mem_dq_i;
    logic [1:0]  req_mask;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;

    always #5 clk = ~clk;

    sram_async_ctrl u_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask),
        .req_ready(req_ready), .req_rdata(req_rdata),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_addr(mem_addr),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // memory model and monitors, sampled on the falling edge
    logic [15:0] mem [0:31] = '{default: 16'h0000};
    int          ncyc = 0, oe_cnt = 0;
    int          we_run = 0, last_we_w = 0, oe_run = 0, last_oe_w = 0;
    int          rdy_run = 0, last_rdy_w = 0;
    int          dqoe_fall = 0, oe_fall = 0, ce_fall = 0, ce_fall_prev = 0, ce_falls = 0;
    logic [16:0] we_addr = '0, oe_addr = '0;
    logic [1:0]  we_be = '0;
    logic        dqoe_q = 1'b0, oe_q = 1'b1, ce_q = 1'b1, drive_bad = 1'b0;

    assign mem_dq_i = (oe_cnt >= OE_W) ? mem[mem_addr[4:0]] : 16'hBAD1;

    always @(negedge clk) begin
        ncyc <= ncyc + 1;
        oe_cnt <= (!mem_oe_n && !mem_ce_n) ? oe_cnt + 1 : 0;
        if (!mem_ce_n && !mem_we_n) begin
            if (!mem_lb_n) mem[mem_addr[4:0]][7:0]  <= mem_dq_o[7:0];
            if (!mem_ub_n) mem[mem_addr[4:0]][15:8] <= mem_dq_o[15:8];
        end
        if (mem_dq_oe != !mem_we_n) drive_bad <= 1'b1;
        if (!mem_we_n) begin
            we_run <= we_run + 1; we_addr <= mem_addr; we_be <= {mem_ub_n, mem_lb_n};
        end else if (we_run != 0) begin
            last_we_w <= we_run; we_run <= 0;
        end
        if (!mem_oe_n) begin
            oe_run <= oe_run + 1; oe_addr <= mem_addr;
        end else if (oe_run != 0) begin
            last_oe_w <= oe_run; oe_run <= 0;
        end
        if (req_ready) rdy_run <= rdy_run + 1;
        else if (rdy_run != 0) begin
            last_rdy_w <= rdy_run; rdy_run <= 0;
        end
        if (dqoe_q && !mem_dq_oe) dqoe_fall <= ncyc;
        if (oe_q && !mem_oe_n)    oe_fall <= ncyc;
        if (ce_q && !mem_ce_n) begin
            ce_fall_prev <= ce_fall; ce_fall <= ncyc; ce_falls <= ce_falls + 1;
        end
        dqoe_q <= mem_dq_oe; oe_q <= mem_oe_n; ce_q <= mem_ce_n;
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_op(input bit wr, input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
        int w = 0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        do begin
            @(negedge clk); w++;
        end while (!req_ready && w < 200);
        #1;
        req_valid = 1'b0;
        if (w >= 200) chk(1'b0, "R6 ready never came", 32'(w), 32'd0);
    endtask

    initial begin
        repeat (100000) @(negedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", ncyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int falls0;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; req_mask = '0;
        repeat (3) @(negedge clk);
        // R1 in reset
        chk({mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready} == 7'b1111100,
            "R1 strobes in reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready}, 7'b1111100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready} == 7'b1111100,
            "R1 strobes idle", {mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready}, 7'b1111100);
        #1;

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [51:0] v;
            v = VEC[i];
            do_op(v[51], v[50:34], v[33:18], v[17:16]);
            if (v[51]) begin
                chk(last_we_w == WE_W, "R2 R10 write strobe width", 32'(last_we_w), 32'(WE_W));
                chk(we_addr == v[50:34], "R3 write address", 32'(we_addr), 32'(v[50:34]));
                chk(we_be == ~v[17:16], "R4 byte enables", 32'(we_be), 32'(~v[17:16]));
            end else begin
                chk(req_rdata == v[15:0], "R5 R4 read data", 32'(req_rdata), 32'(v[15:0]));
                chk(last_oe_w == OE_W, "R5 R10 output enable width", 32'(last_oe_w), 32'(OE_W));
                chk(oe_addr == v[50:34], "R3 read address", 32'(oe_addr), 32'(v[50:34]));
            end
        end

        // R6: read data held across a write
        do_op(1'b1, 17'h00005, 16'hA5A5, 2'b11);
        chk(req_rdata == 16'h0F0F, "R6 read data held", 32'(req_rdata), 32'h0F0F);

        // R9: request fields changed while in flight
        falls0 = ce_falls;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00003; req_wdata = 16'h7777; req_mask = 2'b11;
        repeat (2) @(negedge clk);
        #1;
        req_addr = 17'h00004; req_wdata = 16'h1111; req_write = 1'b0; req_mask = 2'b01;
        while (!req_ready) @(negedge clk);
        #1;
        req_valid = 1'b0;
        chk(ce_falls - falls0 == 1, "R9 one access only", 32'(ce_falls - falls0), 32'd1);
        chk(we_addr == 17'h00003, "R9 latched address", 32'(we_addr), 32'h3);
        do_op(1'b0, 17'h00003, 16'h0000, 2'b11);
        chk(req_rdata == 16'h7777, "R9 latched data", 32'(req_rdata), 32'h7777);
        do_op(1'b0, 17'h00004, 16'h0000, 2'b11);
        chk(req_rdata == 16'h0000, "R9 other word untouched", 32'(req_rdata), 32'h0);

        // R8: write followed at once by read
        do_op(1'b1, 17'h00006, 16'hC3C3, 2'b11);
        do_op(1'b0, 17'h00006, 16'h0000, 2'b11);
        chk(oe_fall - dqoe_fall >= TA_W, "R8 turnaround gap", 32'(oe_fall - dqoe_fall), 32'(TA_W));
        chk(req_rdata == 16'hC3C3, "R8 read after turn", 32'(req_rdata), 32'hC3C3);

        // R7: back-to-back reads and writes
        do_op(1'b0, 17'h00006, 16'h0000, 2'b11);
        chk(ce_fall - ce_fall_prev >= CYC_W, "R7 read spacing", 32'(ce_fall - ce_fall_prev), 32'(CYC_W));
        do_op(1'b1, 17'h00007, 16'h2468, 2'b11);
        do_op(1'b1, 17'h00008, 16'h1357, 2'b11);
        chk(ce_fall - ce_fall_prev >= CYC_W, "R7 write spacing", 32'(ce_fall - ce_fall_prev), 32'(CYC_W));

        repeat (3) @(negedge clk);
        chk(last_rdy_w == 1, "R6 ready width", 32'(last_rdy_w), 32'd1);
        chk(!drive_bad, "R2 driver only with strobe low", 32'(drive_bad), 32'd0);
        chk({mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe} == 6'b111110,
            "R1 idle after traffic", {mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe}, 6'b111110);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule